// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a page-organised serial flash model. It watches chip select, serial clock and serial data input, all oversampled in the system clock domain. Every command begins when chip select falls. An 8-bit opcode follows, then a 24-bit address field, both most significant bit first. The opcode selects one of three transfers: read from a scratch buffer, write into a scratch buffer, or read from a main-array page. The two scratch buffers each hold 528 bytes and sit inside the block.

For a main-page read, the block passes the page and start byte to a separate array engine as a one-cycle command strobe. It then pulls one byte at a time from that engine over a valid/ready stream. A byte moves when `pg_ready` and `pg_valid` are both high in the same cycle. The front-end raises `pg_ready` for exactly one cycle per byte, and only at the moment it needs that byte. The engine cannot hold that byte back. If `pg_valid` is low in that cycle, the byte is taken as 0xFF and the byte address still advances.

Serial output changes only after a falling serial-clock edge, so the host sees a settled bit at its next rising edge. The clock mode (idle-low or idle-high) is latched at every chip-select fall and shown on a plain status pin.

Top module: `flashfe_top`

## Requirements
- R1: While reset is held, and after it is released, `so_oe` is 0, `clk_mode` is 1, and `cmd_valid` and `pg_ready` are 0.
- R2: At each chip-select fall, `clk_mode` takes the serial clock level (0 when idle low, 1 when idle high). It holds that value until the next fall.
- R3: Buffer write uses opcode 0x84 for buffer 0 and 0x87 for buffer 1. The address field is 14 ignored bits and then a 10-bit start byte. Every later group of 8 bits is stored MSB first at consecutive addresses. A write to one buffer leaves the other unchanged.
- R4: Buffer read uses opcode 0x56 for buffer 1 and 0x54 for buffer 0. The address field has the same layout as for a write, and 8 dummy bits follow it. After that, the bytes come out MSB first on `so`, one bit per falling serial-clock edge.
- R5: In every streaming transfer, the byte address moves from 527 back to 0 within the same buffer or page.
- R6: A start byte of 528 or above is mapped according to `ADDR_MODE`. With 0 (the default) it becomes address−528. With 1 it becomes 527.
- R7: Opcode 0x52 starts a main-page read. Its address field carries one reserved bit, then a 13-bit page in bits 22:10, then a 10-bit byte in bits 9:0. `cmd_valid` pulses for one cycle after the 32nd sampled bit and carries that page and that byte.
- R8: After the 32 dummy bits of a page read, each byte is fetched with a single `pg_ready` cycle that carries `pg_page` and `pg_byte`. The byte is `pg_data` when `pg_valid` is high, and 0xFF when it is low.
- R9: A chip-select rise ends the command and drops `so_oe`, and a write byte that is still incomplete is discarded. If a byte's eighth bit is sampled in the same cycle that the rise is seen, that byte is still stored.
- R10: An unrecognised opcode is ignored until chip select rises. It produces no output enable, no command strobe and no buffer change.
- R11: `so_oe` is high only in the data phase of a read. It is never high during the opcode, address or dummy bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from host, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| clk_mode | output | 1 | Latched clock mode, 1 = idle high |
| cmd_valid | output | 1 | One-cycle main-page read strobe |
| cmd_page | output | 13 | Page address for the strobe |
| cmd_byte | output | 10 | Start byte for the strobe |
| pg_ready | output | 1 | Front-end takes one page byte this cycle |
| pg_page | output | 13 | Page of the requested byte |
| pg_byte | output | 10 | Byte address of the requested byte |
| pg_valid | input | 1 | Engine has `pg_data` for the requested address |
| pg_data | input | 8 | Page byte from the engine |

## Verification
Two events can land in the same system-clock cycle: the eighth rising serial-clock edge that completes a write byte, and the chip-select rise that ends the command. The bench provokes this by raising `sck` and `cs_n` in the same time step. Both pass through synchronisers of identical depth, so the design sees them in the same cycle. A later buffer read then shows whether that byte was stored. A second check on the same rule drops chip select three bits into a byte, and the read shows that the neighbouring location kept its old value.

// File: rtl/flashfe_pkg.sv
package flashfe_pkg;
  localparam int OPC_BITS  = 8;
  localparam int ADDR_BITS = 24;
  localparam int BRD_DUMMY = 8;
  localparam int PRD_DUMMY = 32;
  localparam int BYTE_W    = 10;
  localparam int PAGE_W    = 13;

  localparam logic [7:0] OP_BUF0_RD = 8'h54;
  localparam logic [7:0] OP_BUF1_RD = 8'h56;
  localparam logic [7:0] OP_BUF0_WR = 8'h84;
  localparam logic [7:0] OP_BUF1_WR = 8'h87;
  localparam logic [7:0] OP_PAGE_RD = 8'h52;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_WDATA, ST_RDATA, ST_DEAD} fe_state_e;
  typedef enum logic [1:0] {K_BUFRD, K_BUFWR, K_PAGERD, K_NONE} fe_kind_e;

  typedef struct packed {
    fe_kind_e kind;
    logic     sel;
  } fe_op_t;

  function automatic fe_op_t decode_op(input logic [7:0] op);
    fe_op_t r;
    r.kind = K_NONE;
    r.sel  = 1'b0;
    case (op)
      OP_BUF0_RD: r.kind = K_BUFRD;
      OP_BUF1_RD: begin r.kind = K_BUFRD; r.sel = 1'b1; end
      OP_BUF0_WR: r.kind = K_BUFWR;
      OP_BUF1_WR: begin r.kind = K_BUFWR; r.sel = 1'b1; end
      OP_PAGE_RD: r.kind = K_PAGERD;
      default:    r.kind = K_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/flashfe_sync.sv
module flashfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_level,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_level
);
  localparam int NSIG = 3;
  // bit order {cs_n, sck, si}; idle values: deselected, clock high, data low
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b110;

  logic [NSIG-1:0] raw_in, synced;
  logic [1:0]      prev;

  assign raw_in = {cs_n, sck, si};

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], raw_in[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE_VAL[2:1];
    else        prev <= synced[2:1];
  end

  assign cs_fall   =  prev[1] & ~synced[2];
  assign cs_rise   = ~prev[1] &  synced[2];
  assign sck_rise  = ~prev[0] &  synced[1];
  assign sck_fall  =  prev[0] & ~synced[1];
  assign sck_level =  synced[1];
  assign si_level  =  synced[0];
endmodule

// File: rtl/flashfe_buf.sv
module flashfe_buf #(
  parameter int DEPTH = 528,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flashfe_seq.sv
module flashfe_seq
  import flashfe_pkg::*;
#(
  parameter int BUF_BYTES = 528,
  parameter int ADDR_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_level,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_level,
  output logic              so,
  output logic              so_oe,
  output logic              clk_mode,
  output logic              cmd_valid,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              pg_ready,
  output logic [PAGE_W-1:0] pg_page,
  output logic [BYTE_W-1:0] pg_byte,
  input  logic              pg_valid,
  input  logic [7:0]        pg_data,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_sel,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int CNT_W   = 7;
  localparam int FIELD_W = BYTE_W + PAGE_W;
  localparam logic [CNT_W-1:0] C_OPC  = CNT_W'(OPC_BITS);
  localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(OPC_BITS + ADDR_BITS);
  localparam logic [CNT_W-1:0] C_BRD  = CNT_W'(OPC_BITS + ADDR_BITS + BRD_DUMMY);
  localparam logic [CNT_W-1:0] C_PRD  = CNT_W'(OPC_BITS + ADDR_BITS + PRD_DUMMY);
  localparam logic [BYTE_W-1:0] DEPTH_V = BYTE_W'(BUF_BYTES);
  localparam logic [BYTE_W-1:0] LAST_V  = BYTE_W'(BUF_BYTES - 1);

  fe_state_e         state;
  fe_kind_e          kind;
  logic              sel;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [FIELD_W-2:0] shreg;
  logic [FIELD_W-1:0] field;
  logic [BYTE_W-1:0] byte_raw, byte_fold;
  logic [PAGE_W-1:0] hdr_page;
  logic [BYTE_W-1:0] ptr, ptr_inc;
  logic [PAGE_W-1:0] page_q;
  logic              mode3;
  logic [6:0]        wshift;
  logic [2:0]        wcnt;
  logic [7:0]        oshift;
  logic [2:0]        ocnt;
  logic              so_q;
  logic [7:0]        fetch_byte;
  logic              load_now;
  fe_op_t            dec;

  assign cnt_nxt  = cnt + 1'b1;
  assign field    = {shreg, si_level};
  assign byte_raw = field[BYTE_W-1:0];
  assign hdr_page = field[FIELD_W-1:BYTE_W];
  assign dec      = decode_op(field[7:0]);
  assign ptr_inc  = (ptr == LAST_V) ? '0 : ptr + 1'b1;

  // out-of-range start byte policy
  if (ADDR_MODE == 0) begin : g_fold_mod
    assign byte_fold = (byte_raw >= DEPTH_V) ? byte_raw - DEPTH_V : byte_raw;
  end else begin : g_fold_clamp
    assign byte_fold = (byte_raw > LAST_V) ? LAST_V : byte_raw;
  end

  assign load_now   = (state == ST_RDATA) && sck_fall && (ocnt == 3'd0) && !cs_rise && !cs_fall;
  assign pg_ready   = load_now && (kind == K_PAGERD);
  assign fetch_byte = (kind == K_PAGERD) ? (pg_valid ? pg_data : 8'hFF) : rd_data;

  assign wr_en   = (state == ST_WDATA) && sck_rise && (wcnt == 3'd7);
  assign wr_sel  = sel;
  assign wr_addr = ptr;
  assign wr_data = {wshift, si_level};
  assign rd_sel  = sel;
  assign rd_addr = ptr;
  assign pg_page = page_q;
  assign pg_byte = ptr;
  assign so      = so_q;
  assign so_oe   = (state == ST_RDATA);
  assign clk_mode = mode3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= K_NONE;
      sel       <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      ptr       <= '0;
      page_q    <= '0;
      mode3     <= 1'b1;
      cmd_valid <= 1'b0;
      cmd_page  <= '0;
      cmd_byte  <= '0;
      wshift    <= '0;
      wcnt      <= '0;
      oshift    <= '0;
      ocnt      <= '0;
      so_q      <= 1'b1;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_rise) begin
        state <= ST_IDLE;
      end else if (cs_fall) begin
        state <= ST_HDR;
        kind  <= K_NONE;
        cnt   <= '0;
        mode3 <= sck_level;
        so_q  <= 1'b1;
        ocnt  <= '0;
        wcnt  <= '0;
      end else begin
        case (state)
          ST_HDR: if (sck_rise) begin
            shreg <= field[FIELD_W-2:0];
            cnt   <= cnt_nxt;
            if (cnt_nxt == C_OPC) begin
              kind <= dec.kind;
              sel  <= dec.sel;
              if (dec.kind == K_NONE) state <= ST_DEAD;
            end
            if (cnt_nxt == C_ADDR) begin
              ptr    <= byte_fold;
              page_q <= hdr_page;
              if (kind == K_BUFWR) state <= ST_WDATA;
              if (kind == K_PAGERD) begin
                cmd_valid <= 1'b1;
                cmd_page  <= hdr_page;
                cmd_byte  <= byte_fold;
              end
            end
            if ((cnt_nxt == C_BRD) && (kind == K_BUFRD)) state <= ST_RDATA;
            if ((cnt_nxt == C_PRD) && (kind == K_PAGERD)) state <= ST_RDATA;
          end
          ST_WDATA: if (sck_rise) begin
            wshift <= {wshift[5:0], si_level};
            wcnt   <= wcnt + 1'b1;
            if (wcnt == 3'd7) ptr <= ptr_inc;
          end
          ST_RDATA: if (sck_fall) begin
            if (ocnt == 3'd0) begin
              so_q   <= fetch_byte[7];
              oshift <= {fetch_byte[6:0], 1'b0};
              ocnt   <= 3'd7;
              ptr    <= ptr_inc;
            end else begin
              so_q   <= oshift[7];
              oshift <= {oshift[6:0], 1'b0};
              ocnt   <= ocnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flashfe_top.sv
module flashfe_top
  import flashfe_pkg::*;
#(
  parameter int BUF_BYTES   = 528,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_MODE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              clk_mode,
  output logic              cmd_valid,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              pg_ready,
  output logic [PAGE_W-1:0] pg_page,
  output logic [BYTE_W-1:0] pg_byte,
  input  logic              pg_valid,
  input  logic [7:0]        pg_data
);
  localparam int NBUF = 2;

  logic cs_fall, cs_rise, sck_level, sck_rise, sck_fall, si_level;
  logic wr_en, wr_sel, rd_sel;
  logic [BYTE_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [NBUF-1:0][7:0] rd_q;

  flashfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_level(sck_level),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_level(si_level)
  );

  flashfe_seq #(.BUF_BYTES(BUF_BYTES), .ADDR_MODE(ADDR_MODE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_level(sck_level),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_level(si_level),
    .so(so), .so_oe(so_oe), .clk_mode(clk_mode),
    .cmd_valid(cmd_valid), .cmd_page(cmd_page), .cmd_byte(cmd_byte),
    .pg_ready(pg_ready), .pg_page(pg_page), .pg_byte(pg_byte),
    .pg_valid(pg_valid), .pg_data(pg_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    flashfe_buf #(.DEPTH(BUF_BYTES), .AW(BYTE_W)) u_buf (
      .clk(clk),
      .we(wr_en && (wr_sel == 1'(g))),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_addr),
      .rdata(rd_q[g])
    );
  end

  assign rd_data = rd_q[rd_sel];
endmodule

// File: rtl/flashfe_chk.sv
module flashfe_chk #(
  parameter int BUF_BYTES = 528
) (
  input logic       clk,
  input logic       rst_n,
  input logic       so,
  input logic       so_oe,
  input logic       clk_mode,
  input logic       cmd_valid,
  input logic       pg_ready,
  input logic [9:0] pg_byte,
  input logic       cs_rise_i,
  input logic       cs_fall_i,
  input logic       sck_fall_i
);
  localparam logic [9:0] LIM = 10'(BUF_BYTES);

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid) else $error("cmd strobe longer than one cycle"); // R7
  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ready |=> !pg_ready) else $error("fetch longer than one cycle"); // R8
  AST_FETCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ready |-> (pg_byte < LIM)) else $error("byte address past end"); // R5
  AST_OE_OFF_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> !so_oe) else $error("output still driven after deselect"); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall_i |=> $stable(clk_mode)) else $error("clock mode moved without select"); // R2
  AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && !sck_fall_i) |=> (!so_oe || $stable(so))) else $error("so moved without falling edge"); // R4
  AST_NO_OE_AT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !so_oe) else $error("output enabled during header"); // R11
endmodule

bind flashfe_top flashfe_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_oe(so_oe), .clk_mode(clk_mode),
  .cmd_valid(cmd_valid), .pg_ready(pg_ready), .pg_byte(pg_byte),
  .cs_rise_i(cs_rise), .cs_fall_i(cs_fall), .sck_fall_i(sck_fall)
);

// File: tb/tb_flashfe_top.sv
module tb_flashfe_top;
  localparam int NB   = 528;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b1, si = 1'b0, pg_valid = 1'b1;
  logic so, so_oe, clk_mode, cmd_valid, pg_ready;
  logic [12:0] cmd_page, pg_page;
  logic [9:0]  cmd_byte, pg_byte;
  logic [7:0]  pg_data;

  int errors = 0, checks = 0, cmd_cnt = 0, rdy_cnt = 0;
  logic [12:0] seen_page = '0;
  logic [9:0]  seen_byte = '0;
  logic [7:0]  model [2][NB];

  always #10 clk = ~clk;

  flashfe_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .clk_mode(clk_mode),
    .cmd_valid(cmd_valid), .cmd_page(cmd_page), .cmd_byte(cmd_byte),
    .pg_ready(pg_ready), .pg_page(pg_page), .pg_byte(pg_byte),
    .pg_valid(pg_valid), .pg_data(pg_data)
  );

  function automatic logic [7:0] page_pat(input logic [12:0] p, input logic [9:0] b);
    return b[7:0] ^ {p[4:0], p[12:10]} ^ {6'd0, b[9:8]} ^ 8'h3C;
  endfunction

  function automatic logic [9:0] fold(input logic [9:0] a);
    return (a >= 10'd528) ? a - 10'd528 : a;
  endfunction

  function automatic logic [9:0] nxt(input logic [9:0] a);
    return (a == 10'd527) ? 10'd0 : a + 10'd1;
  endfunction

  assign pg_data = page_pat(pg_page, pg_byte);

  always @(negedge clk) begin
    if (cmd_valid) begin
      cmd_cnt++;
      seen_page = cmd_page;
      seen_byte = cmd_byte;
    end
    if (pg_ready) rdy_cnt++;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin(input bit m3);
    sck = m3; tick(4); cs_n = 1'b0; tick(6);
  endtask

  task automatic cs_end(input bit m3);
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    sck = 1'b0; si = b; tick(HALF); sck = 1'b1; tick(HALF);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; tick(HALF); v[i] = so; sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic buf_hdr(input logic [7:0] op, input logic [9:0] a);
    put_byte(op);
    for (int i = 23; i >= 0; i--) put_bit(i < 10 ? a[i] : 1'($urandom % 2));
  endtask

  task automatic buf_write(input bit b, input bit m3, input logic [9:0] a, input int n);
    logic [9:0] p;
    logic [7:0] d;
    p = fold(a);
    cs_begin(m3);
    buf_hdr(b ? 8'h87 : 8'h84, a);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      put_byte(d);
      model[b][p] = d;
      p = nxt(p);
    end
    cs_end(m3);
  endtask

  task automatic buf_read(input bit b, input bit m3, input logic [9:0] a, input int n, input string req);
    logic [9:0] p;
    logic [7:0] v;
    p = fold(a);
    cs_begin(m3);
    buf_hdr(b ? 8'h56 : 8'h54, a);
    for (int i = 0; i < 8; i++) put_bit(1'($urandom % 2));
    for (int k = 0; k < n; k++) begin
      get_byte(v);
      check(req, "buffer byte", {24'd0, v}, {24'd0, model[b][p]});
      p = nxt(p);
    end
    check("R11", "so_oe in data phase", {31'd0, so_oe}, 32'd1);
    cs_end(m3);
    check("R9", "so_oe after deselect", {31'd0, so_oe}, 32'd0);
  endtask

  task automatic page_read(input logic [12:0] pg, input logic [9:0] a, input int n, input bit valid);
    int c0, r0;
    logic [9:0] p;
    logic [7:0] v;
    pg_valid = valid;
    c0 = cmd_cnt;
    cs_begin(1'b1);
    put_byte(8'h52);
    put_bit(1'b0);
    for (int i = 12; i >= 0; i--) put_bit(pg[i]);
    for (int i = 9; i >= 0; i--) put_bit(a[i]);
    check("R7", "cmd strobe count", cmd_cnt - c0, 1);
    check("R7", "cmd page", {19'd0, seen_page}, {19'd0, pg});
    check("R7", "cmd byte", {22'd0, seen_byte}, {22'd0, a});
    for (int i = 0; i < 31; i++) put_bit(1'($urandom % 2));
    check("R11", "so_oe before last dummy", {31'd0, so_oe}, 32'd0);
    put_bit(1'b1);
    check("R11", "so_oe at data start", {31'd0, so_oe}, 32'd1);
    r0 = rdy_cnt;
    p = a;
    for (int k = 0; k < n; k++) begin
      get_byte(v);
      check("R8", "page byte", {24'd0, v}, {24'd0, valid ? page_pat(pg, p) : 8'hFF});
      p = nxt(p);
    end
    check("R8", "fetch count", rdy_cnt - r0, n);
    cs_end(1'b1);
    check("R9", "so_oe after page read", {31'd0, so_oe}, 32'd0);
    pg_valid = 1'b1;
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'd1357));
    tick(5);
    check("R1", "so_oe in reset", {31'd0, so_oe}, 32'd0);
    rst_n = 1'b1;
    tick(5);
    check("R1", "so_oe", {31'd0, so_oe}, 32'd0);
    check("R1", "clk_mode", {31'd0, clk_mode}, 32'd1);
    check("R1", "cmd_valid", {31'd0, cmd_valid}, 32'd0);
    check("R1", "pg_ready", {31'd0, pg_ready}, 32'd0);

    // R2: mode follows idle clock level
    cs_begin(1'b0);
    check("R2", "mode idle low", {31'd0, clk_mode}, 32'd0);
    cs_end(1'b0);
    check("R2", "mode held after deselect", {31'd0, clk_mode}, 32'd0);
    cs_begin(1'b1);
    check("R2", "mode idle high", {31'd0, clk_mode}, 32'd1);
    cs_end(1'b1);

    // R3 R4: random writes and reads in both modes
    for (int r = 0; r < 6; r++) begin
      bit b, mw, mr;
      logic [9:0] a;
      int n;
      b  = 1'($urandom % 2);
      mw = 1'($urandom % 2);
      mr = 1'($urandom % 2);
      a  = 10'($urandom % NB);
      n  = 3 + int'($urandom % 8);
      buf_write(b, mw, a, n);
      buf_read(b, mr, a, n, "R3 R4");
    end

    // R5: wrap at the end of a buffer
    buf_write(1'b1, 1'b0, 10'd525, 6);
    buf_read(1'b1, 1'b1, 10'd525, 6, "R5");

    // R6: start 600 maps to 72; R3: other buffer untouched
    buf_write(1'b0, 1'b1, 10'd600, 3);
    buf_write(1'b1, 1'b0, 10'd72, 3);
    buf_read(1'b0, 1'b0, 10'd72, 3, "R6 R3");
    buf_read(1'b1, 1'b1, 10'd72, 3, "R3");

    // R7 R8: page read across the page end, then underrun
    page_read(13'h1ABC, 10'd526, 4, 1'b1);
    page_read(13'h0042, 10'd10, 2, 1'b0);

    // R10: unknown opcode ignored
    begin
      int c0;
      c0 = cmd_cnt;
      cs_begin(1'b0);
      buf_hdr(8'h99, 10'd72);
      for (int i = 0; i < 48; i++) put_bit(1'($urandom % 2));
      check("R10", "so_oe for unknown op", {31'd0, so_oe}, 32'd0);
      cs_end(1'b0);
      check("R10", "no cmd strobe", cmd_cnt - c0, 0);
      buf_read(1'b0, 1'b0, 10'd72, 3, "R10");
    end

    // R9: partial byte dropped
    buf_write(1'b0, 1'b1, 10'd100, 2);
    cs_begin(1'b1);
    buf_hdr(8'h84, 10'd100);
    d = 8'hA5;
    put_byte(d);
    model[0][100] = d;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    cs_end(1'b1);
    buf_read(1'b0, 1'b0, 10'd100, 2, "R9");

    // R9: eighth bit and deselect in the same cycle
    cs_begin(1'b1);
    buf_hdr(8'h84, 10'd200);
    d = 8'h6B;
    for (int i = 7; i >= 1; i--) put_bit(d[i]);
    sck = 1'b0; si = d[0]; tick(HALF);
    sck = 1'b1; cs_n = 1'b1; tick(10);
    model[0][200] = d;
    buf_read(1'b0, 1'b1, 10'd200, 1, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule